// File: doc/BRIEF.md
# FP32 Result Composition Stage

This block is the last, registered step of a shared special-function pipeline. It takes a 27-bit fixed-point polynomial value, a signed 8-bit exponent, a sign bit and a function code. From these it builds a single-precision word. Each function has its own rule. Exponential and square root rebias the exponent upward. Reciprocal and reciprocal square root subtract the exponent from 126. The logarithm joins the integer exponent and the fraction into one signed fixed-point number and normalizes it. Sine and cosine normalize a value in [0, 1] and saturate at one.

A special-value filter upstream can raise a bypass flag and supply a finished word. That word replaces the computed result. The stage takes one input per cycle and has a latency of one cycle. A valid bit travels with the data.

Top module: `sfu_compose`

## Requirements
- R1: `valid_o` equals `valid_i` from the previous clock edge. After reset, `valid_o` is 0 and `result_o` is 0.
- R2: A cycle with `valid_i` low leaves `result_o` unchanged, whatever the other inputs hold.
- R3: When `valid_i` and `bypass_i` are both high, the next `result_o` equals `bypass_val_i`, whatever the function code.
- R4: Function codes 0 (exponential) and 3 (square root) produce {`sign_i`, (127 + `exp_i`) mod 256, `poly_i`[24:2]}.
- R5: Function codes 2 (reciprocal) and 4 (reciprocal square root) produce {`sign_i`, (126 − `exp_i`) mod 256, `poly_i`[24:2]}.
- R6: Function code 1 (logarithm) reads {`exp_i`, `poly_i`[25:0]} as a signed two's-complement value scaled by 2^-26. The result is that value in FP32. The sign comes from `exp_i`, and `sign_i` is ignored. Mantissa bits below the 23 kept bits are truncated.
- R7: For function code 1, an all-zero {`exp_i`, `poly_i`[25:0]} produces +0.0 (0x00000000).
- R8: Function codes 5 (sine) and 6 (cosine), when `poly_i`[26:25] is 0, produce `poly_i`[24:0]·2^-25 in FP32. The result carries sign `sign_i` and a truncated mantissa. A zero fraction gives a signed zero.
- R9: For codes 5 and 6, when `poly_i`[26] is 0 and `poly_i`[25] is 1, the result is ±1.0 ({`sign_i`, 0x7F, 23'b0}).
- R10: For codes 5 and 6, when `poly_i`[26] is 1 (a negative polynomial), the result is a signed zero {`sign_i`, 31'b0}.
- R11: Function code 7 is reserved and produces the quiet NaN 0x7FC00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operands are valid |
| func_i | input | 3 | Function code (0 exp2, 1 log2, 2 rcp, 3 sqrt, 4 rsqrt, 5 sin, 6 cos, 7 reserved) |
| poly_i | input | 27 | Polynomial result, fixed point, 1.0 = 2^25 |
| exp_i | input | 8 | Signed exponent or integer part |
| sign_i | input | 1 | Result sign for the non-logarithm functions |
| bypass_i | input | 1 | Special-case override |
| bypass_val_i | input | 32 | Word that is output when the override is set |
| valid_o | output | 1 | Output word is valid |
| result_o | output | 32 | Composed FP32 word |

## Verification
The hardest case to reach is the logarithm normalizer at the extremes of its 34-bit span. These are the most negative exponent, whose magnitude has a lone top bit after negation, and fractions that put the leading one below the mantissa width, so the shift fills zeros. The stimulus sweeps all 256 exponents against walking-one and all-ones fractions. The trigonometric path is driven with a leading one at every one of its 25 positions. The expected words come from converting the exact value to double precision in the bench and truncating that word.

// File: rtl/sfu_compose_pkg.sv
package sfu_compose_pkg;
  typedef enum logic [2:0] {
    FN_EXP2  = 3'd0,
    FN_LOG2  = 3'd1,
    FN_RCP   = 3'd2,
    FN_SQRT  = 3'd3,
    FN_RSQRT = 3'd4,
    FN_SIN   = 3'd5,
    FN_COS   = 3'd6,
    FN_RSVD  = 3'd7
  } fn_e;

  localparam int FP_EXP_W = 8;
  localparam int FP_MAN_W = 23;
  localparam int FP_BIAS  = 127;
  localparam logic [31:0] FP_QNAN = 32'h7FC0_0000;
endpackage

// File: rtl/sfu_lzc.sv
module sfu_lzc #(
  parameter int W  = 34,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  in_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  logic [CW-1:0] cnt;

  // Ascending scan: the highest set bit is written last.
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (in_i[i]) cnt = CW'(W - 1 - i);
    end
  end

  assign cnt_o  = cnt;
  assign zero_o = (in_i == '0);
endmodule

// File: rtl/sfu_norm.sv
module sfu_norm #(
  parameter int W         = 34,
  parameter int FRAC_BITS = 26,
  parameter int EXP_W     = 8,
  parameter int MAN_W     = 23,
  parameter int BIAS      = 127
) (
  input  logic                     sign_i,
  input  logic [W-1:0]             mag_i,
  output logic [EXP_W+MAN_W:0]     word_o
);
  localparam int CW    = $clog2(W + 1);
  localparam int E_TOP = BIAS - FRAC_BITS + W - 1;

  logic [CW-1:0]    lz;
  logic             is_zero;
  logic [W-1:0]     shifted;
  logic [15:0]      e_full;
  logic [EXP_W-1:0] e_fld;
  logic [MAN_W-1:0] man;

  sfu_lzc #(.W(W), .CW(CW)) u_lzc (
    .in_i   (mag_i),
    .cnt_o  (lz),
    .zero_o (is_zero)
  );

  assign shifted = mag_i << lz;
  assign e_full  = 16'(E_TOP) - 16'(lz);
  assign e_fld   = e_full[EXP_W-1:0];
  assign man     = shifted[W-2 -: MAN_W];

  always_comb begin
    if (is_zero) word_o = {sign_i, {(EXP_W + MAN_W){1'b0}}};
    else         word_o = {sign_i, e_fld, man};
  end

  // The shifter and the zero counter must agree on where the leading one sits.
  always_comb begin
    if (!is_zero && mag_i[0] !== 1'bx) begin
      assert_norm_msb_R6: assert (shifted[W-1] == 1'b1)
        else $error("normalizer leading bit missing");
    end
  end
endmodule

// File: rtl/sfu_compose.sv
module sfu_compose
  import sfu_compose_pkg::*;
#(
  parameter int POLY_W     = 27,
  parameter int EXP_W      = 8,
  parameter int LOG_FRAC_W = 26,
  parameter int UNIT_POS   = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        func_i,
  input  logic [POLY_W-1:0] poly_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              sign_i,
  input  logic              bypass_i,
  input  logic [31:0]       bypass_val_i,
  output logic              valid_o,
  output logic [31:0]       result_o
);
  localparam int LOG_W = EXP_W + LOG_FRAC_W;
  localparam logic [FP_EXP_W-1:0] BIAS_UP = FP_EXP_W'(FP_BIAS);
  localparam logic [FP_EXP_W-1:0] BIAS_DN = FP_EXP_W'(FP_BIAS - 1);
  localparam logic [30:0] ONE_MAG = {BIAS_UP, {FP_MAN_W{1'b0}}};

  fn_e fn;
  assign fn = fn_e'(func_i);

  // Direct rebias paths
  logic [FP_EXP_W-1:0] exp_up, exp_dn;
  logic [FP_MAN_W-1:0] man_direct;
  assign exp_up     = BIAS_UP + FP_EXP_W'(exp_i);
  assign exp_dn     = BIAS_DN - FP_EXP_W'(exp_i);
  assign man_direct = poly_i[UNIT_POS-1 -: FP_MAN_W];

  // Logarithm: signed fixed point {exp, frac}
  logic [LOG_W-1:0] log_fix, log_mag;
  logic             log_neg;
  logic [31:0]      log_word;
  assign log_fix = {exp_i, poly_i[LOG_FRAC_W-1:0]};
  assign log_neg = log_fix[LOG_W-1];
  assign log_mag = log_neg ? (~log_fix + 1'b1) : log_fix;

  sfu_norm #(
    .W(LOG_W), .FRAC_BITS(LOG_FRAC_W),
    .EXP_W(FP_EXP_W), .MAN_W(FP_MAN_W), .BIAS(FP_BIAS)
  ) u_log_norm (
    .sign_i (log_neg),
    .mag_i  (log_mag),
    .word_o (log_word)
  );

  // Trigonometric: fraction in [0,1)
  logic [31:0] trig_norm_word, trig_word;
  logic        trig_neg, trig_ovf;
  assign trig_neg = poly_i[POLY_W-1];
  assign trig_ovf = |poly_i[POLY_W-2:UNIT_POS];

  sfu_norm #(
    .W(UNIT_POS), .FRAC_BITS(UNIT_POS),
    .EXP_W(FP_EXP_W), .MAN_W(FP_MAN_W), .BIAS(FP_BIAS)
  ) u_trig_norm (
    .sign_i (sign_i),
    .mag_i  (poly_i[UNIT_POS-1:0]),
    .word_o (trig_norm_word)
  );

  always_comb begin
    if (trig_neg)      trig_word = {sign_i, 31'b0};
    else if (trig_ovf) trig_word = {sign_i, ONE_MAG};
    else               trig_word = trig_norm_word;
  end

  logic [31:0] comp_word;
  always_comb begin
    unique case (fn)
      FN_EXP2, FN_SQRT:  comp_word = {sign_i, exp_up, man_direct};
      FN_RCP, FN_RSQRT:  comp_word = {sign_i, exp_dn, man_direct};
      FN_LOG2:           comp_word = log_word;
      FN_SIN, FN_COS:    comp_word = trig_word;
      default:           comp_word = FP_QNAN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= bypass_i ? bypass_val_i : comp_word;
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  assert_bypass_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && bypass_i |=> result_o == $past(bypass_val_i));

  assert_log_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !bypass_i && fn == FN_LOG2 && exp_i == '0 && poly_i[LOG_FRAC_W-1:0] == '0
    |=> result_o == 32'h0);

  assert_trig_clamp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !bypass_i && (fn == FN_SIN || fn == FN_COS) |=> result_o[30:0] <= ONE_MAG);

  assert_reserved_nan_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !bypass_i && fn == FN_RSVD |=> result_o == FP_QNAN);
endmodule

// File: tb/sfu_compose_bench.sv
`timescale 1ns/1ps
module sfu_compose_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  func_i = '0;
  logic [26:0] poly_i = '0;
  logic [7:0]  exp_i = '0;
  logic        sign_i = 1'b0;
  logic        bypass_i = 1'b0;
  logic [31:0] bypass_val_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  sfu_compose u_sfu_compose (
    .clk_i, .rst_ni, .valid_i, .func_i, .poly_i, .exp_i, .sign_i,
    .bypass_i, .bypass_val_i, .valid_o, .result_o
  );

  function automatic logic [31:0] mix(int a);
    logic [31:0] x;
    x = 32'(a) * 32'h9E37_79B1;
    return x ^ (x >> 13) ^ 32'h5A5A_1234;
  endfunction

  // Exact real value converted to double, then truncated to single.
  function automatic logic [31:0] to_sp(real r);
    logic [63:0] b;
    int e;
    if (r == 0.0) return 32'h0;
    b = $realtobits(r);
    e = int'(b[62:52]) - 1023 + 127;
    return {b[63], e[7:0], b[51:29]};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp_v);
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp_v);
    end
  endtask

  // Called at a negedge; drives, waits one cycle, checks at the next negedge.
  task automatic xact(string req, logic [2:0] f, logic [26:0] p, logic [7:0] e,
                      logic s, logic byp, logic [31:0] bv, logic [31:0] exp_v);
    valid_i = 1'b1; func_i = f; poly_i = p; exp_i = e; sign_i = s;
    bypass_i = byp; bypass_val_i = bv;
    @(negedge clk_i);
    check(req, result_o, exp_v);
    checks++;
    if (valid_o !== 1'b1) begin
      errors++;
      $display("FAIL R1: valid_o got %0b expected 1", valid_o);
    end
  endtask

  function automatic logic [31:0] log_ref(logic [7:0] e, logic [25:0] fr);
    logic [33:0] c;
    longint v;
    c = {e, fr};
    v = longint'(signed'(c));
    return to_sp(real'(v) / 67108864.0);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] last;
    repeat (3) @(negedge clk_i);
    check("R1 reset valid", {31'b0, valid_o}, 32'h0);
    check("R1 reset result", result_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4 / R5 direct rebias over every exponent
    for (int e = 0; e < 256; e++) begin
      logic [26:0] p;
      logic [7:0] ev;
      p = mix(e)[26:0];
      ev = 8'(e);
      xact("R4 exp2", 3'd0, p, ev, ev[0], 1'b0, 32'h0, {ev[0], 8'(127 + e), p[24:2]});
      xact("R4 sqrt", 3'd3, ~p, ev, ~ev[0], 1'b0, 32'h0, {~ev[0], 8'(127 + e), ~p[24:2]});
      xact("R5 rcp", 3'd2, p, ev, ev[1], 1'b0, 32'h0, {ev[1], 8'(126 - e), p[24:2]});
      xact("R5 rsqrt", 3'd4, p ^ 27'h155_5555, ev, 1'b0, 1'b0, 32'h0,
           {1'b0, 8'(126 - e), p[24:2] ^ 23'h55_5555});
    end

    // R6 / R7 logarithm across all exponents and edge fractions
    for (int e = 0; e < 256; e++) begin
      for (int k = 0; k < 30; k++) begin
        logic [25:0] fr;
        if (k < 26)       fr = 26'(1) << k;
        else if (k == 26) fr = '0;
        else if (k == 27) fr = '1;
        else              fr = mix(e * 31 + k)[25:0];
        if (e == 0 && fr == '0)
          xact("R7 log zero", 3'd1, {1'b1, fr}, 8'(e), 1'b1, 1'b0, 32'h0, 32'h0);
        else
          xact("R6 log", 3'd1, {k[0], fr}, 8'(e), k[1], 1'b0, 32'h0, log_ref(8'(e), fr));
      end
    end

    // R8 trig with the leading one at every position
    for (int b = 0; b < 25; b++) begin
      for (int k = 0; k < 4; k++) begin
        logic [24:0] fr;
        logic [24:0] low;
        low = (25'(1) << b) - 25'(1);
        fr = (25'(1) << b) | (mix(b * 7 + k)[24:0] & low);
        if (k == 3) fr = (25'(1) << b) | low;
        xact("R8 sin", 3'd5, {2'b00, fr}, mix(b)[7:0], k[0], 1'b0, 32'h0,
             {k[0], to_sp(real'(fr) / 33554432.0)[30:0]});
        xact("R8 cos", 3'd6, {2'b00, fr}, 8'h00, ~k[0], 1'b0, 32'h0,
             {~k[0], to_sp(real'(fr) / 33554432.0)[30:0]});
      end
    end
    xact("R8 trig zero", 3'd5, 27'h0, 8'h03, 1'b1, 1'b0, 32'h0, 32'h8000_0000);
    xact("R8 trig zero", 3'd6, 27'h0, 8'h03, 1'b0, 1'b0, 32'h0, 32'h0000_0000);

    // R9 clamp, R10 negative polynomial
    for (int k = 0; k < 16; k++) begin
      logic [24:0] lo;
      lo = (k == 0) ? 25'h0 : mix(k + 900)[24:0];
      xact("R9 clamp", k[0] ? 3'd5 : 3'd6, {2'b01, lo}, 8'(k), k[1], 1'b0, 32'h0,
           {k[1], 31'h3F80_0000});
      xact("R10 negative", k[0] ? 3'd6 : 3'd5, {1'b1, k[2], lo}, 8'(k), k[1], 1'b0, 32'h0,
           {k[1], 31'h0});
    end

    // R3 bypass on every function code
    for (int k = 0; k < 32; k++) begin
      logic [31:0] bv;
      bv = mix(k + 5000);
      xact("R3 bypass", 3'(k), mix(k)[26:0], mix(k + 1)[7:0], k[3], 1'b1, bv, bv);
    end

    // R11 reserved code
    xact("R11 reserved", 3'd7, 27'h123_4567, 8'h10, 1'b1, 1'b0, 32'h0, 32'h7FC0_0000);

    // R2 idle cycles keep the word; R1 valid drops
    xact("R4 exp2 pre-idle", 3'd0, 27'h0AA_AAAA, 8'h01, 1'b0, 1'b0, 32'h0,
         {1'b0, 8'd128, 23'h2A_AAAA});
    last = result_o;
    for (int k = 0; k < 8; k++) begin
      valid_i = 1'b0; func_i = 3'(k); poly_i = mix(k)[26:0]; exp_i = mix(k + 3)[7:0];
      sign_i = k[0]; bypass_i = k[1]; bypass_val_i = mix(k + 77);
      @(negedge clk_i);
      check("R2 idle hold", result_o, last);
      check("R1 valid low", {31'b0, valid_o}, 32'h0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule